// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory whose read and write cycles may be issued on back-to-back clocks in any mix, with no idle slot on the data bus when the traffic changes direction. Every control, address and data input is captured on the rising edge. A read returns its word two enabled edges after its address is captured. A write takes its data on that same second enabled edge, so a write's data slot lines up with the slot a read would use. The address and lane enables of each operation travel down a two-stage pipeline next to it.

A new operation (read, write or deselect) starts when `load_n` is low. While `load_n` is high, the block continues a four-beat burst from the last captured address. The beat order is linear or interleaved, chosen by `order_ilv`. A read that trails a not-yet-committed write to the same word sees the new bytes, merged lane by lane. A clock-enable input freezes the whole pipeline. A sleep input freezes it as well, floats the bus and keeps the stored data. The block has no internal tristate. It exports the pad enable `rdata_oe`, and a floated bus is shown as `rdata_oe` low with `rdata` at zero.

Top module: `zt_sram`

## Requirements
- R1: The 36-bit word is split into four 9-bit lanes, where lane k is bits [9k+8:9k]. On a write, lane k is stored only when `be_n[k]` is low. The other lanes keep their old contents.
- R2: A read captured at enabled edge t drives its word on `rdata`, with `rdata_oe` high, right after enabled edge t+2.
- R3: The data of a write captured at enabled edge t is taken from `din` at enabled edge t+2. Reads and writes may follow each other on consecutive edges in any order, and every read still returns the correct data.
- R4: With `load_n` low, the block captures a new operation and address. With `load_n` high, it issues the next beat of the current operation. A burst has four beats, and only the two lowest address bits change.
- R5: With `order_ilv` low, beat n uses low bits (start + n) mod 4. With `order_ilv` high, beat n uses start XOR n.
- R6: An edge at which `clk_en_n` is high changes no state. Inputs presented at that edge are ignored, and the pipeline resumes where it stopped.
- R7: The device is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination captured with `load_n` low is a deselect, which writes nothing and floats the bus in its data slot.
- R8: A read captured one enabled edge after a write to the same address returns the written lanes from the write's data and the other lanes from memory.
- R9: While `oe_n` is high, the bus floats at once, without waiting for a clock edge. The bus also floats in the data slot of a write or a deselect.
- R10: While `sleep` is high, no operation is captured or committed and the bus floats. Stored words survive, and the pipeline resumes when `sleep` falls.
- R11: A synchronous reset floats the bus and empties the pipeline. Advance cycles that follow a reset, with no load, issue no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address, captured on load |
| din | input | DW | Write data, captured two enabled edges after its address |
| wr_n | input | 1 | Operation select at load: low write, high read |
| be_n | input | NLANE | Active-low lane write enables, captured every beat |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low: capture a new operation; high: advance the burst |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| order_ilv | input | 1 | Burst order: high interleaved, low linear |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Power-down: freeze, float the bus, keep the contents |
| rdata | output | DW | Registered read data, zero when floated |
| rdata_oe | output | 1 | Pad drive enable for `rdata` |

## Verification
A stage that holds the wrong operation or address shows at the ports exactly two enabled edges later: the bus is driven in a slot that should float, floats in a read slot, or returns a word from the wrong address. A missing or stale forwarding capture leaves the write's lanes at their old values, and this shows only in the read placed directly after that write. Because a burst's beats are issued in order, an error in the beat counter or in the order select shows as a permutation of the returned words. A freeze that leaks shows as data arriving early, or as a discarded write that appears in memory on a later read.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits of burst beat n from a start value.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int NLANE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_n,
  input  logic [NLANE-1:0] be_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             load_n,
  input  logic             order_ilv,
  output op_e              op_o,
  output logic [AW-1:0]    addr_o,
  output logic [NLANE-1:0] lane_o
);
  localparam int BB = 2;  // burst wraps on this many low bits

  op_e           bop_q;
  logic [AW-1:0] base_q;
  logic [BB-1:0] cnt_q;
  logic [BB-1:0] cnt_nx;
  logic          sel;

  always_comb begin
    sel    = !cs1_n && cs2 && !cs3_n;
    cnt_nx = cnt_q + 2'd1;
    if (!load_n) begin
      op_o   = sel ? (wr_n ? OP_READ : OP_WRITE) : OP_NONE;
      addr_o = addr_i;
    end else begin
      op_o   = bop_q;
      addr_o = {base_q[AW-1:BB], beat_low(base_q[BB-1:0], cnt_nx, order_ilv)};
    end
    lane_o = (op_o == OP_WRITE) ? ~be_n : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bop_q  <= OP_NONE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      if (!load_n) begin
        bop_q  <= op_o;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_nx;
      end
    end
  end

  AST_LOAD_RESTARTS_BEAT: assert property (@(posedge clk) disable iff (rst)
    (en && !load_n) |=> (cnt_q == '0)); // R4
  AST_ADVANCE_KEEPS_BASE: assert property (@(posedge clk) disable iff (rst)
    (en && load_n) |=> $stable(base_q)); // R4
  AST_FROZEN_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> ($stable(cnt_q) && $stable(bop_q))); // R6

endmodule

// File: rtl/zt_sram_stage.sv
module zt_sram_stage
  import zt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int NLANE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  op_e              op_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NLANE-1:0] lane_i,
  output op_e              op_o,
  output logic [AW-1:0]    addr_o,
  output logic [NLANE-1:0] lane_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      op_o   <= OP_NONE;
      addr_o <= '0;
      lane_o <= '0;
    end else if (en) begin
      op_o   <= op_i;
      addr_o <= addr_i;
      lane_o <= lane_i;
    end
  end
endmodule

// File: rtl/zt_sram_mem.sv
module zt_sram_mem #(
  parameter int AW    = 6,
  parameter int DW    = 36,
  parameter int NLANE = 4
) (
  input  logic             clk,
  input  logic             en,
  input  logic [NLANE-1:0] we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  localparam int LW    = DW / NLANE;
  localparam int DEPTH = 1 << AW;

  // One simple dual-port array per lane, read-before-write.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LW-1:0] ram [DEPTH];
    logic [LW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en) begin
        if (we[g]) ram[waddr] <= wdata[g*LW +: LW];
        rd_q <= ram[raddr];
      end
    end

    assign rdata[g*LW +: LW] = rd_q;
  end
endmodule

// File: rtl/zt_sram_fwd.sv
module zt_sram_fwd
  import zt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 36,
  parameter int NLANE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  op_e              rd_op,
  input  logic [AW-1:0]    rd_addr,
  input  op_e              wr_op,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NLANE-1:0] wr_lane,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    mem_q,
  output logic [DW-1:0]    merged
);
  localparam int LW = DW / NLANE;

  logic [NLANE-1:0] hit_q;
  logic [DW-1:0]    fdat_q;

  // Captured on the edge where the write commits and the read samples memory.
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= '0;
      fdat_q <= '0;
    end else if (en) begin
      hit_q  <= (rd_op == OP_READ && wr_op == OP_WRITE && rd_addr == wr_addr)
                ? wr_lane : '0;
      fdat_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_merge
    assign merged[g*LW +: LW] = hit_q[g] ? fdat_q[g*LW +: LW] : mem_q[g*LW +: LW];
  end

  AST_FWD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|hit_q) |-> $past(wr_op == OP_WRITE)); // R8

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 36,
  parameter int NLANE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic             wr_n,
  input  logic [NLANE-1:0] be_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             load_n,
  input  logic             clk_en_n,
  input  logic             order_ilv,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);
  localparam int PIPE = 2;  // enabled edges from capture to data slot

  logic             en;
  op_e              op_p   [PIPE+1];
  logic [AW-1:0]    addr_p [PIPE+1];
  logic [NLANE-1:0] lane_p [PIPE+1];
  logic [NLANE-1:0] mem_we;
  logic [DW-1:0]    mem_q;
  logic [DW-1:0]    merged;
  logic [DW-1:0]    q_q;
  logic             outv_q;

  assign en = !clk_en_n && !sleep;

  zt_sram_ctrl #(.AW(AW), .NLANE(NLANE)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .addr_i(addr), .wr_n(wr_n), .be_n(be_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .load_n(load_n),
    .order_ilv(order_ilv), .op_o(op_p[0]), .addr_o(addr_p[0]), .lane_o(lane_p[0])
  );

  for (genvar g = 0; g < PIPE; g++) begin : g_stage
    zt_sram_stage #(.AW(AW), .NLANE(NLANE)) u_stage (
      .clk(clk), .rst(rst), .en(en),
      .op_i(op_p[g]), .addr_i(addr_p[g]), .lane_i(lane_p[g]),
      .op_o(op_p[g+1]), .addr_o(addr_p[g+1]), .lane_o(lane_p[g+1])
    );
  end

  assign mem_we = (op_p[PIPE] == OP_WRITE) ? lane_p[PIPE] : '0;

  zt_sram_mem #(.AW(AW), .DW(DW), .NLANE(NLANE)) u_mem (
    .clk(clk), .en(en), .we(mem_we), .waddr(addr_p[PIPE]), .wdata(din),
    .raddr(addr_p[PIPE-1]), .rdata(mem_q)
  );

  zt_sram_fwd #(.AW(AW), .DW(DW), .NLANE(NLANE)) u_fwd (
    .clk(clk), .rst(rst), .en(en),
    .rd_op(op_p[PIPE-1]), .rd_addr(addr_p[PIPE-1]),
    .wr_op(op_p[PIPE]), .wr_addr(addr_p[PIPE]), .wr_lane(lane_p[PIPE]),
    .wr_data(din), .mem_q(mem_q), .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outv_q <= 1'b0;
      q_q    <= '0;
    end else if (en) begin
      outv_q <= (op_p[PIPE] == OP_READ);
      if (op_p[PIPE] == OP_READ) q_q <= merged;
    end
  end

  assign rdata_oe = outv_q && !oe_n && !sleep;
  assign rdata    = rdata_oe ? q_q : '0;

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(q_q) && $stable(outv_q))); // R6
  AST_SLEEP_KEEPS_OUT: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(q_q) && $stable(op_p[PIPE]))); // R10
  AST_OE_FLOATS: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!rdata_oe && rdata == '0)); // R9
  AST_WRITE_SLOT_FLOATS: assert property (@(posedge clk) disable iff (rst)
    (en && op_p[PIPE] != OP_READ) |=> !rdata_oe); // R9

endmodule

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam logic [2:0] SEL = 3'b010;  // {cs1_n, cs2, cs3_n}
  localparam logic [2:0] DES = 3'b110;
  localparam logic [DW-1:0] D4 = 36'h1_2345_6789;
  localparam logic [DW-1:0] D5 = 36'h9_8765_4321;
  localparam logic [DW-1:0] FF = 36'hF_FFFF_FFFF;
  localparam logic [DW-1:0] MG = 36'h1_2347_FFFF;  // D4 with lanes 0,1 set
  localparam logic [DW-1:0] JK = 36'h0_DEAD_BEEF;

  typedef struct packed {
    logic          ld;
    logic          w;
    logic          s;
    logic [3:0]    be;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          eoe;
    logic [DW-1:0] ed;
  } vec_t;

  // One row per clock: inputs, then the bus state right after that edge.
  localparam vec_t TBL [12] = '{
    '{1'b0, 1'b0, 1'b1, 4'h0, 6'd4, 36'h0, 1'b0, 36'h0}, // write 4
    '{1'b0, 1'b0, 1'b1, 4'h0, 6'd5, 36'h0, 1'b0, 36'h0}, // write 5
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd4, D4,    1'b0, 36'h0}, // read 4, data of write 4, slot floats R9
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd5, D5,    1'b0, 36'h0}, // read 5, data of write 5
    '{1'b0, 1'b0, 1'b1, 4'hC, 6'd4, 36'h0, 1'b1, D4},    // write lanes 0,1 of 4, R3 turn
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd4, 36'h0, 1'b1, D5},    // read 4 right after write R8
    '{1'b0, 1'b1, 1'b0, 4'hF, 6'd0, FF,    1'b0, 36'h0}, // deselect, carries write data
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd4, 36'h0, 1'b1, MG},    // forwarded merge R1
    '{1'b0, 1'b1, 1'b0, 4'hF, 6'd0, 36'h0, 1'b0, 36'h0},
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 36'h0, 1'b1, MG},    // committed merge R1
    '{1'b0, 1'b1, 1'b0, 4'hF, 6'd0, 36'h0, 1'b0, 36'h0},
    '{1'b0, 1'b1, 1'b0, 4'hF, 6'd0, 36'h0, 1'b1, D5}     // R2 latency
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          wr_n = 1'b1;
  logic [3:0]    be_n = 4'hF;
  logic          cs1_n = 1'b1;
  logic          cs2 = 1'b1;
  logic          cs3_n = 1'b0;
  logic          load_n = 1'b0;
  logic          clk_en_n = 1'b0;
  logic          order_ilv = 1'b0;
  logic          oe_n = 1'b0;
  logic          sleep = 1'b0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] model [64];

  always #2.5 clk = ~clk;

  zt_sram #(.AW(AW), .DW(DW), .NLANE(4)) uut (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .wr_n(wr_n), .be_n(be_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .load_n(load_n),
    .clk_en_n(clk_en_n), .order_ilv(order_ilv), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [AW-1:0] bseq(input logic [AW-1:0] s, input int n,
                                         input logic ilv);
    logic [1:0] nb;
    nb = 2'(n);
    return {s[AW-1:2], ilv ? (s[1:0] ^ nb) : (s[1:0] + nb)};
  endfunction

  function automatic logic [DW-1:0] vpat(input int n);
    return {4'h5, 32'hC0DE_0000 + 32'(n)};
  endfunction

  task automatic chk(input string req, input logic eoe, input logic [DW-1:0] ed);
    total++;
    if (rdata_oe !== eoe || rdata !== (eoe ? ed : '0)) begin
      bad++;
      $display("FAIL %s: actual oe=%0b data=%h expected oe=%0b data=%h",
               req, rdata_oe, rdata, eoe, eoe ? ed : '0);
    end
  endtask

  task automatic step(input logic ld, input logic w, input logic [2:0] cs,
                      input logic [3:0] be, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    load_n = ld; wr_n = w; {cs1_n, cs2, cs3_n} = cs; be_n = be; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, DES, 4'hF, '0, '0);
  endtask

  task automatic read_one(input logic [AW-1:0] a, input string req);
    step(1'b0, 1'b1, SEL, 4'hF, a, '0);
    idle(2);
    chk(req, 1'b1, model[a]);
  endtask

  initial begin
    // R11: reset state and advance-after-reset
    idle(3);
    rst = 1'b0;
    chk("R11 reset floats bus", 1'b0, '0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, SEL, 4'hF, 6'd4, '0);
      chk("R11 advance after reset issues nothing", 1'b0, '0);
    end
    idle(2);

    // R1 R2 R3 R8 R9: vector table
    for (int i = 0; i < 12; i++) begin
      step(TBL[i].ld, TBL[i].w, TBL[i].s ? SEL : DES, TBL[i].be, TBL[i].a, TBL[i].d);
      chk($sformatf("R1 R2 R3 R8 R9 table row %0d", i), TBL[i].eoe, TBL[i].ed);
    end
    model[4] = MG;
    model[5] = D5;
    idle(2);

    // R4: linear burst write from 10 (order 10,11,8,9)
    order_ilv = 1'b0;
    for (int k = 0; k < 6; k++)
      step((k == 0 || k >= 4) ? 1'b0 : 1'b1, 1'b0, (k >= 4) ? DES : SEL, 4'h0,
           6'd10, (k >= 2) ? vpat(k - 2) : '0);
    for (int n = 0; n < 4; n++) model[bseq(6'd10, n, 1'b0)] = vpat(n);
    idle(2);

    // R5: interleaved burst read from 9 (order 9,8,11,10)
    order_ilv = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step((k == 0 || k >= 4) ? 1'b0 : 1'b1, 1'b1, (k >= 4) ? DES : SEL, 4'hF, 6'd9, '0);
      if (k >= 2) chk("R5 interleaved beat", 1'b1, model[bseq(6'd9, k - 2, 1'b1)]);
    end
    idle(2);

    // R4: linear burst read from 11 (order 11,8,9,10)
    order_ilv = 1'b0;
    for (int k = 0; k < 6; k++) begin
      step((k == 0 || k >= 4) ? 1'b0 : 1'b1, 1'b1, (k >= 4) ? DES : SEL, 4'hF, 6'd11, '0);
      if (k >= 2) chk("R4 linear beat", 1'b1, model[bseq(6'd11, k - 2, 1'b0)]);
    end
    idle(3);

    // R6: clock hold freezes an in-flight read and ignores a write
    step(1'b0, 1'b1, SEL, 4'hF, 6'd10, '0);
    clk_en_n = 1'b1;
    for (int h = 0; h < 3; h++) begin
      step(1'b0, 1'b0, SEL, 4'h0, 6'd10, JK);
      chk("R6 held edge changes nothing", 1'b0, '0);
    end
    clk_en_n = 1'b0;
    idle(1);
    chk("R6 one enabled edge after hold", 1'b0, '0);
    idle(1);
    chk("R6 read completes after hold", 1'b1, model[10]);
    idle(2);
    read_one(6'd10, "R6 held write was ignored");
    idle(2);

    // R7: partial selects are deselects
    step(1'b0, 1'b0, 3'b000, 4'h0, 6'd10, JK);
    step(1'b0, 1'b0, 3'b011, 4'h0, 6'd10, JK);
    step(1'b0, 1'b1, DES, 4'hF, 6'd10, JK);
    chk("R7 deselect slot floats", 1'b0, '0);
    step(1'b0, 1'b1, DES, 4'hF, 6'd10, JK);
    chk("R7 deselect slot floats", 1'b0, '0);
    read_one(6'd10, "R7 deselect wrote nothing");

    // R9: output enable acts between edges
    oe_n = 1'b1;
    #1;
    chk("R9 oe_n high floats at once", 1'b0, '0);
    oe_n = 1'b0;
    #1;
    chk("R9 oe_n low drives again", 1'b1, model[10]);

    // R10: sleep floats, ignores writes, keeps contents and pipeline
    sleep = 1'b1;
    #1;
    chk("R10 sleep floats bus", 1'b0, '0);
    for (int h = 0; h < 3; h++) begin
      step(1'b0, 1'b0, SEL, 4'h0, 6'd11, JK);
      chk("R10 no access in sleep", 1'b0, '0);
    end
    sleep = 1'b0;
    #1;
    chk("R10 held word returns after sleep", 1'b1, model[10]);
    idle(2);
    read_one(6'd11, "R10 contents kept");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule